// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block is a general-purpose periodic timer behind a small register interface. Software writes a prescale value, a reload value and a few control bits. The block then divides its clock by the prescale value plus one and counts up at that slower rate. Each time the count reaches the reload value, it returns to zero and signals an update.

An update sets a sticky status flag. When the interrupt enable is set, the flag drives the interrupt line. Software clears the flag by writing a zero to it. The prescale value is always double-buffered and takes effect at the next update. The reload value can either take effect at once or be buffered the same way. Software can also force an update, block updates, or stop forced updates from setting the flag.

The bus is a single-cycle write port with a combinational read-back selected by the same address.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low; register offsets are control 0, interrupt enable 1, status 2, force 3, count 4, prescale 5, reload 6.
- R2: Starting from count 0 with prescale P and reload A, the count reads floor(n/(P+1)) mod (A+1) n cycles after the run bit (control bit 0) is set, and the first update lands exactly (P+1)*(A+1) cycles after that write.
- R3: When the count equals the reload value on a counting step, the count becomes 0 and the status flag (status bit 0) is set.
- R4: `irq` is high exactly when the status flag is set and the enable (interrupt-enable bit 0) is set; the flag itself is set regardless of the enable.
- R5: Writing 0 to status bit 0 clears the flag; writing 1 leaves it unchanged.
- R6: With the run bit clear, the count holds its value.
- R7: With the preload bit (control bit 7) clear, a reload write takes effect at once; with it set, the written value takes effect only at the next update.
- R8: With the update-off bit (control bit 1) set, the count still wraps to 0 at the reload value, but the flag is not set, the buffered values are not loaded and forced updates are ignored.
- R9: Writing 1 to force bit 0 clears the count and prescaler and loads both buffered values; it sets the flag only when the overflow-only bit (control bit 2) is clear.
- R10: A prescale write takes effect only at the next update.
- R11: If an overflow and a software clear of the flag fall in the same cycle, the flag ends up set.
- R12: A write to the count register replaces the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset for writes and read-back |
| wdata | input | W | Write data |
| rdata | output | W | Read-back of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: the hardware setting the flag at an overflow, and software clearing it through a status write. The bench sets the reload to 3 with no prescaling and starts the counter. It waits three cycles and then times the clear so that its write edge is the wrap edge. The result is judged in the following cycle: the interrupt must still be high and the count must read zero. Other edge-exact checks cover reload and prescale writes made while the timer runs, and the first period after each of them is measured to the exact cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_IEN   = 3'd1,
        RA_STAT  = 3'd2,
        RA_FORCE = 3'd3,
        RA_CNT   = 3'd4,
        RA_PSC   = 3'd5,
        RA_RLD   = 3'd6
    } reg_addr_e;

    localparam int BIT_RUN     = 0;
    localparam int BIT_UPDOFF  = 1;
    localparam int BIT_OVFONLY = 2;
    localparam int BIT_PRELOAD = 7;
    localparam int CTRL_BYTE   = 8;

    typedef struct packed {
        logic preload;
        logic ovf_only;
        logic upd_off;
        logic run;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [CTRL_BYTE-1:0] b);
        ctrl_t c;
        c.run      = b[BIT_RUN];
        c.upd_off  = b[BIT_UPDOFF];
        c.ovf_only = b[BIT_OVFONLY];
        c.preload  = b[BIT_PRELOAD];
        return c;
    endfunction

    function automatic logic [CTRL_BYTE-1:0] ctrl_encode(input ctrl_t c);
        logic [CTRL_BYTE-1:0] b;
        b = '0;
        b[BIT_RUN]     = c.run;
        b[BIT_UPDOFF]  = c.upd_off;
        b[BIT_OVFONLY] = c.ovf_only;
        b[BIT_PRELOAD] = c.preload;
        return b;
    endfunction

endpackage

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    input  logic         flag_set,
    output ctrl_t        ctrl,
    output logic         ie,
    output logic         flag,
    output logic         force_req,
    output logic         cnt_wr,
    output logic         psc_wr,
    output logic         rld_wr
);
    logic ctrl_wr, ie_wr, stat_wr;

    always_comb begin
        ctrl_wr   = wr_en && (addr == RA_CTRL);
        ie_wr     = wr_en && (addr == RA_IEN);
        stat_wr   = wr_en && (addr == RA_STAT);
        force_req = wr_en && (addr == RA_FORCE) && wdata[0];
        cnt_wr    = wr_en && (addr == RA_CNT);
        psc_wr    = wr_en && (addr == RA_PSC);
        rld_wr    = wr_en && (addr == RA_RLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ie   <= 1'b0;
            flag <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= ctrl_decode(wdata[CTRL_BYTE-1:0]);
            if (ie_wr)   ie   <= wdata[0];
            // hardware set outranks a software clear in the same cycle
            if (flag_set)                flag <= 1'b1;
            else if (stat_wr && !wdata[0]) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/tick_shadow.sv
module tick_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         direct,
    input  logic         load,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= '0;
            active <= '0;
        end else begin
            if (wr) shadow <= wdata;
            if (wr && direct)  active <= wdata;
            else if (load)     active <= wr ? wdata : shadow;
        end
    end
endmodule

// File: rtl/tick_core.sv
module tick_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         upd_off,
    input  logic         ovf_only,
    input  logic [W-1:0] psc_act,
    input  logic [W-1:0] rld_act,
    input  logic         force_req,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic         tick,
    output logic         wrap,
    output logic         upd_evt,
    output logic         flag_set
);
    logic [W-1:0] pdiv_q;

    always_comb begin
        tick     = run && (pdiv_q == psc_act);
        wrap     = tick && (cnt == rld_act);
        upd_evt  = !upd_off && (wrap || force_req);
        flag_set = !upd_off && (wrap || (force_req && !ovf_only));
    end

    always_ff @(posedge clk) begin
        if (rst)                 pdiv_q <= '0;
        else if (upd_evt || tick) pdiv_q <= '0;
        else if (run)            pdiv_q <= pdiv_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (cnt_wr)         cnt <= wdata;
        else if (upd_evt || wrap) cnt <= '0;
        else if (tick)           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         irq
);
    localparam int PAD = W - CTRL_BYTE;

    ctrl_t        ctrl_q;
    logic         ie_q, flag_q, force_req, cnt_wr, psc_wr, rld_wr;
    logic         tick, wrap, upd_evt, flag_set;
    logic [W-1:0] cnt_q, psc_sh, psc_act, rld_sh, rld_act;

    tick_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .flag_set(flag_set), .ctrl(ctrl_q), .ie(ie_q), .flag(flag_q),
        .force_req(force_req), .cnt_wr(cnt_wr), .psc_wr(psc_wr), .rld_wr(rld_wr)
    );

    // prescale is always buffered; reload is direct unless preload is set
    tick_shadow #(.W(W)) u_psc (
        .clk(clk), .rst(rst), .wr(psc_wr), .wdata(wdata), .direct(1'b0),
        .load(upd_evt), .shadow(psc_sh), .active(psc_act)
    );

    tick_shadow #(.W(W)) u_rld (
        .clk(clk), .rst(rst), .wr(rld_wr), .wdata(wdata), .direct(!ctrl_q.preload),
        .load(upd_evt), .shadow(rld_sh), .active(rld_act)
    );

    tick_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .run(ctrl_q.run), .upd_off(ctrl_q.upd_off),
        .ovf_only(ctrl_q.ovf_only), .psc_act(psc_act), .rld_act(rld_act),
        .force_req(force_req), .cnt_wr(cnt_wr), .wdata(wdata), .cnt(cnt_q),
        .tick(tick), .wrap(wrap), .upd_evt(upd_evt), .flag_set(flag_set)
    );

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = {{PAD{1'b0}}, ctrl_encode(ctrl_q)};
            RA_IEN:  rdata = {{(W-1){1'b0}}, ie_q};
            RA_STAT: rdata = {{(W-1){1'b0}}, flag_q};
            RA_CNT:  rdata = cnt_q;
            RA_PSC:  rdata = psc_sh;
            RA_RLD:  rdata = rld_sh;
            default: rdata = '0;
        endcase
    end

    assign irq = flag_q && ie_q;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic [W-1:0] wdata,
    input ctrl_t        ctrl,
    input logic         flag,
    input logic [W-1:0] cnt,
    input logic [W-1:0] rld_act,
    input logic         wrap,
    input logic         upd_evt
);
    assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (wrap && !(wr_en && addr == RA_CNT)) |=> (cnt == '0));

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && addr == RA_STAT && !wdata[0])) |=> flag);

    assert_hold_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !wr_en) |=> $stable(cnt));

    assert_preload_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.preload && !upd_evt) |=> $stable(rld_act));

    assert_updoff_no_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl.upd_off && !flag) |=> !flag);
endmodule

bind tick_timer tick_timer_chk #(.W(W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .ctrl(ctrl_q), .flag(flag_q), .cnt(cnt_q), .rld_act(rld_act),
    .wrap(wrap), .upd_evt(upd_evt)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
    localparam int W = 16;
    localparam int A_CTRL = 0, A_IEN = 1, A_STAT = 2, A_FORCE = 3;
    localparam int A_CNT = 4, A_PSC = 5, A_RLD = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    tick_timer #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 3'(a);
        wdata = W'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        addr  = 3'(A_CNT);
    endtask

    task automatic rd(input int a, output int v);
        addr = 3'(a);
        #0.5;
        v = int'(rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_flag(input int max, output int n);
        n = 0;
        while (!irq && n < max) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    task automatic setup(input int ctrl, input int p, input int a);
        wr(A_CTRL, ctrl);
        wr(A_PSC, p);
        wr(A_RLD, a);
        wr(A_FORCE, 1);
        wr(A_STAT, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete actual=1 expected=0");
        finish_run();
    end

    initial begin
        int v, n;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset values on every offset
        for (int a = 0; a < 7; a++) begin
            rd(a, v);
            check($sformatf("R1 reg%0d", a), v, 0);
        end
        check("R1 irq", int'(irq), 0);

        wr(A_IEN, 1);

        // R2/R3: sweep prescale and reload
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 6; a++) begin
                int period;
                period = (p + 1) * (a + 1);
                setup(0, p, a);
                wr(A_CTRL, 1);
                for (int k = 1; k <= period; k++) begin
                    idle(1);
                    rd(A_CNT, v);
                    check($sformatf("R2 cnt p%0d a%0d n%0d", p, a, k), v, (k / (p + 1)) % (a + 1));
                    check($sformatf("R3 flag p%0d a%0d n%0d", p, a, k), int'(irq), (k == period) ? 1 : 0);
                end
            end
        end

        // R12 and R6: count write, then hold while stopped
        wr(A_CTRL, 0);
        wr(A_CNT, 3);
        rd(A_CNT, v);
        check("R12 count write", v, 3);
        idle(5);
        rd(A_CNT, v);
        check("R6 hold stopped", v, 3);

        // R7: preloaded reload waits for the next update
        setup(8'h80, 0, 9);
        wr(A_RLD, 2);
        wr(A_CTRL, 8'h81);
        wait_flag(100, n);
        check("R7 buffered old period", n, 10);
        wr(A_STAT, 0);
        wait_flag(100, n);
        check("R7 buffered new period", n, 2);

        // R7: direct reload acts at once
        setup(0, 0, 9);
        wr(A_CTRL, 1);
        idle(2);
        wr(A_RLD, 4);
        wait_flag(100, n);
        check("R7 direct reload", n, 2);

        // R10: prescale written while running waits for update
        setup(0, 0, 3);
        wr(A_CTRL, 1);
        wr(A_PSC, 1);
        wait_flag(100, n);
        check("R10 old prescale period", n, 3);
        wr(A_STAT, 0);
        wait_flag(100, n);
        check("R10 new prescale period", n, 7);

        // R11: overflow and software clear on the same edge
        setup(0, 0, 3);
        wr(A_CTRL, 1);
        idle(3);
        wr(A_STAT, 0);
        check("R11 set beats clear", int'(irq), 1);
        rd(A_CNT, v);
        check("R3 wrap count", v, 0);

        // R8: update-off wraps silently, ignores force and buffers
        setup(0, 0, 2);
        wr(A_CTRL, 8'h83);
        wr(A_RLD, 5);
        idle(9);
        rd(A_CNT, v);
        check("R8 wraps count", v, 1);
        check("R8 no flag", int'(irq), 0);
        wr(A_FORCE, 1);
        rd(A_CNT, v);
        check("R8 force ignored", v, 2);
        check("R8 still no flag", int'(irq), 0);

        // R9: forced update with overflow-only set
        wr(A_CTRL, 8'h04);
        wr(A_CNT, 7);
        wr(A_FORCE, 1);
        rd(A_CNT, v);
        check("R9 force clears count", v, 0);
        check("R9 overflow-only no flag", int'(irq), 0);
        wr(A_CTRL, 8'h05);
        wait_flag(100, n);
        check("R9 force loaded reload", n, 6);
        wr(A_CTRL, 0);
        wr(A_STAT, 0);
        wr(A_FORCE, 1);
        check("R9 force sets flag", int'(irq), 1);

        // R5: clear by zero only
        wr(A_STAT, 1);
        check("R5 write one keeps", int'(irq), 1);
        wr(A_STAT, 0);
        check("R5 write zero clears", int'(irq), 0);
        wr(A_STAT, 1);
        check("R5 write one no set", int'(irq), 0);

        // R4: enable gates the line, not the flag
        wr(A_IEN, 0);
        wr(A_FORCE, 1);
        check("R4 masked irq", int'(irq), 0);
        rd(A_STAT, v);
        check("R4 flag set while masked", v, 1);
        wr(A_IEN, 1);
        check("R4 irq enabled", int'(irq), 1);

        finish_run();
    end
endmodule